// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder Model

This block is a synthesizable behavioural stand-in for a 16-bit extended-data-out dynamic RAM. It is meant to sit opposite a memory controller under verification. It oversamples the active-low strobes (row strobe, two byte-lane column strobes, write enable, output enable) and the multiplexed address on a fast system clock. From the sampled edges it works out what kind of cycle the controller is running. It then writes the selected byte lanes of a small array, or presents read data on a registered output bus with per-lane drive enables.

The cycle type is set by whichever column strobe falls first. Write masking and output drive stay per byte lane. Read data keeps being driven after the column strobes rise, which gives the extended hold that page-mode controllers rely on. The drive ends only when the row strobe and both column strobes are high together, or when output enable or write enable cuts it off. The decoded cycle type comes out on a debug port so that a bench can check the controller's intent directly.

Every strobe event is acted on at the first clock edge that samples it. All outputs change at that same edge.

Top module: `edo_dram_model`

## Requirements
- R1: If either column strobe is low at the edge where the row strobe is first seen low, the cycle is a CAS-before-RAS refresh: `cyc_type` becomes 5, no array write happens (even with write enable low), and the array content is unchanged.
- R2: A write stores `din[15:8]` only if `ucas_n` is low at the write event, and stores `din[7:0]` only if `lcas_n` is low at the write event. A lane whose strobe is high keeps its old byte.
- R3: If `we_n` is low at the edge where the first column strobe falls, the cycle is an early write: `cyc_type` becomes 2, the word at {row, column} is written, and `dq_en` stays 0.
- R4: A column strobe fall with `we_n` high is a read of the word at {latched row, current address}. `dq_out` shows that word at the same edge. `dq_en` has bit 1 set if `ucas_n` is low and bit 0 set if `lcas_n` is low, gated by output enable. `cyc_type` is 1 if `oe_n` is low, and 7 (output-disabled read) while output enable has stayed high since the access.
- R5: Read data stays driven after both column strobes rise while the row strobe is low. `dq_en` returns to 0 at the first edge where the row strobe and both column strobes are high.
- R6: Output enable rising turns `dq_en` off. If it rises while both column strobes are high, the output stays off until the next column access. If it rises while a column strobe is low, it lowering again restores the drive.
- R7: Write enable falling while both column strobes are high turns the output off until the next column access.
- R8: Write enable falling while a column strobe is low, after a read access, writes `din` at the latched {row, column}. `cyc_type` becomes 4 (read-modify-write) if output enable was seen low in that access, else 3 (delayed write). In both cases `dq_en` goes to 0, and before the write the read data was presented.
- R9: A row strobe fall with both column strobes high latches the row address and gives `cyc_type` 6 with `dq_en` 0, and leaves the array unchanged.
- R10: Further column strobe falls while the row strobe stays low are page accesses at the latched row and the new column.
- R11: After reset `cyc_type` is 0 and `dq_en` is 0. `cyc_type` keeps its last value until the next event that reclassifies it.
- R12: A byte-lane column strobe that falls after the other lane's strobe, within the same access, adds its lane to `dq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | K | Multiplexed row/column address |
| din | input | 2*LW | Write data, upper lane in the top byte |
| dq_out | output | 2*LW | Registered read data |
| dq_en | output | 2 | Per-lane drive enable, bit 1 upper |
| cyc_type | output | 3 | Decoded cycle class (0 standby … 7 output-disabled read) |

## Verification
The assertions assume that each strobe holds its level for at least one clock so that every edge is sampled, and that the column strobes are never staggered across a write. They also assume the row strobe never falls on the same edge at which a column strobe that had driven read data rises. The bench keeps within these limits: its tasks change one group of strobes per clock, and they return every strobe high between cycles. The random mix only chooses cycle kinds, addresses, lanes and data inside those legal sequences.

// File: rtl/edo_cyc_pkg.sv
package edo_cyc_pkg;

    typedef enum logic [2:0] {
        CYC_IDLE = 3'd0,
        CYC_READ = 3'd1,
        CYC_EWR  = 3'd2,
        CYC_DWR  = 3'd3,
        CYC_RMW  = 3'd4,
        CYC_CBR  = 3'd5,
        CYC_ROR  = 3'd6,
        CYC_RDZ  = 3'd7
    } cyc_e;

    localparam int NSTROBE = 5;
    localparam int SI_RAS  = 4;
    localparam int SI_UC   = 3;
    localparam int SI_LC   = 2;
    localparam int SI_WE   = 1;
    localparam int SI_OE   = 0;

endpackage

// File: rtl/strobe_tap.sv
module strobe_tap #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] smp_d, smp_q;

    always_comb begin
        smp_d = d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '1;
        else        smp_q <= smp_d;
    end

    assign q = smp_q;

endmodule

// File: rtl/lane_store.sv
module lane_store #(
    parameter int AW = 6,
    parameter int LW = 8,
    parameter int LANES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES-1:0]    wr_en,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            end else if (wr_en[g]) begin
                mem_q[addr] <= wdata[g*LW +: LW];
            end
        end

        assign rdata[g*LW +: LW] = mem_q[addr];
    end

endmodule

// File: rtl/cyc_ctrl.sv
module cyc_ctrl
    import edo_cyc_pkg::*;
#(
    parameter int K  = 3,
    parameter int LW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ras_n,
    input  logic                ucas_n,
    input  logic                lcas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [K-1:0]        addr,
    input  logic [NSTROBE-1:0]  smp,
    input  logic [2*LW-1:0]     rdata,
    output logic [2*K-1:0]      mem_addr,
    output logic [1:0]          wr_en,
    output logic [2*LW-1:0]     data,
    output logic [1:0]          drive_en,
    output cyc_e                cyc
);
    localparam int DW = 2 * LW;

    typedef struct packed {
        cyc_e          cyc;
        logic [K-1:0]  row;
        logic [K-1:0]  col;
        logic [DW-1:0] data;
        logic [1:0]    lane;
        logic          armed;
    } st_t;

    st_t  s_d, s_q;
    logic cas_hi, cas_hi_p, ras_fall, cas_fall, uc_fall, lc_fall;
    logic oe_rise, we_fall;

    always_comb begin
        cas_hi   = ucas_n & lcas_n;
        cas_hi_p = smp[SI_UC] & smp[SI_LC];
        ras_fall = smp[SI_RAS] & ~ras_n;
        cas_fall = cas_hi_p & ~cas_hi;
        uc_fall  = smp[SI_UC] & ~ucas_n;
        lc_fall  = smp[SI_LC] & ~lcas_n;
        oe_rise  = ~smp[SI_OE] & oe_n;
        we_fall  = smp[SI_WE] & ~we_n;

        s_d      = s_q;
        wr_en    = '0;
        mem_addr = {s_q.row, s_q.col};

        if (ras_fall) begin
            if (!cas_hi) begin
                s_d.cyc = CYC_CBR;
            end else begin
                s_d.cyc   = CYC_ROR;
                s_d.row   = addr;
                s_d.armed = 1'b0;
            end
        end else if (!ras_n && cas_fall && s_q.cyc != CYC_CBR) begin
            s_d.col  = addr;
            mem_addr = {s_q.row, addr};
            s_d.lane = {~ucas_n, ~lcas_n};
            if (!we_n) begin
                s_d.cyc   = CYC_EWR;
                wr_en     = {~ucas_n, ~lcas_n};
                s_d.armed = 1'b0;
            end else begin
                s_d.cyc   = oe_n ? CYC_RDZ : CYC_READ;
                s_d.data  = rdata;
                s_d.armed = 1'b1;
            end
        end else begin
            if (!ras_n && !cas_hi && s_q.cyc != CYC_CBR) begin
                if (uc_fall) s_d.lane[1] = 1'b1;
                if (lc_fall) s_d.lane[0] = 1'b1;
                if (we_fall && (s_q.cyc == CYC_READ || s_q.cyc == CYC_RDZ)) begin
                    s_d.cyc   = (s_q.cyc == CYC_READ) ? CYC_RMW : CYC_DWR;
                    wr_en     = {~ucas_n, ~lcas_n};
                    s_d.armed = 1'b0;
                end
            end
            if (cas_hi && (oe_rise || we_fall)) s_d.armed = 1'b0;
            if (ras_n && cas_hi)                s_d.armed = 1'b0;
            if (s_d.armed && !oe_n && s_d.cyc == CYC_RDZ) s_d.cyc = CYC_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cyc   <= CYC_IDLE;
            s_q.row   <= '0;
            s_q.col   <= '0;
            s_q.data  <= '0;
            s_q.lane  <= '0;
            s_q.armed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data     = s_q.data;
    assign drive_en = {2{s_q.armed & ~smp[SI_OE]}} & s_q.lane;
    assign cyc      = s_q.cyc;

    // R2: a lane is written only while its own strobe and the row strobe are low
    p_upper_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[1] |-> (!ucas_n && !ras_n));
    p_lower_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[0] |-> (!lcas_n && !ras_n));

    // R1: a refresh cycle never writes the array
    p_cbr_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cyc == CYC_CBR) |-> (wr_en == 2'b00));

    // R5: drive ends only on full release, OE rise, WE low, or a row-only refresh
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.armed) |-> ((smp[SI_RAS] && smp[SI_UC] && smp[SI_LC])
                              || $rose(smp[SI_OE]) || !smp[SI_WE]
                              || s_q.cyc == CYC_ROR));

    // R4: any driven lane belongs to a read or to a hidden refresh after one
    p_drive_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en != 2'b00) |-> (s_q.cyc == CYC_READ || s_q.cyc == CYC_CBR));

endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model
    import edo_cyc_pkg::*;
#(
    parameter int K  = 3,
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ras_n,
    input  logic            ucas_n,
    input  logic            lcas_n,
    input  logic            we_n,
    input  logic            oe_n,
    input  logic [K-1:0]    addr,
    input  logic [2*LW-1:0] din,
    output logic [2*LW-1:0] dq_out,
    output logic [1:0]      dq_en,
    output logic [2:0]      cyc_type
);
    localparam int AW = 2 * K;
    localparam int DW = 2 * LW;

    logic [NSTROBE-1:0] smp;
    logic [AW-1:0]      mem_addr;
    logic [1:0]         wr_en;
    logic [DW-1:0]      rdata;
    cyc_e               cyc;

    strobe_tap #(.N(NSTROBE)) u_tap (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ras_n, ucas_n, lcas_n, we_n, oe_n}),
        .q     (smp)
    );

    cyc_ctrl #(.K(K), .LW(LW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .ucas_n   (ucas_n),
        .lcas_n   (lcas_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .smp      (smp),
        .rdata    (rdata),
        .mem_addr (mem_addr),
        .wr_en    (wr_en),
        .data     (dq_out),
        .drive_en (dq_en),
        .cyc      (cyc)
    );

    lane_store #(.AW(AW), .LW(LW), .LANES(2)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (mem_addr),
        .wr_en (wr_en),
        .wdata (din),
        .rdata (rdata)
    );

    assign cyc_type = cyc;

    // R3: an early write never drives the bus
    p_early_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_EWR) |-> (dq_en == 2'b00));

    // R8: delayed write and read-modify-write leave the bus undriven
    p_late_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_DWR || cyc_type == CYC_RMW) |-> (dq_en == 2'b00));

    // R9: a row-only refresh keeps outputs open
    p_ror_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_ROR) |-> (dq_en == 2'b00));

endmodule

// File: tb/sim_edo_dram_model.sv
module sim_edo_dram_model;

    localparam int K  = 3;
    localparam int LW = 8;
    localparam int WORDS = 1 << (2 * K);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [K-1:0]    addr = '0;
    logic [2*LW-1:0] din = '0;
    logic [2*LW-1:0] dq_out;
    logic [1:0]      dq_en;
    logic [2:0]      cyc_type;

    logic [15:0] ref_mem [WORDS];
    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    edo_dram_model #(.K(K), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
        .dq_out(dq_out), .dq_en(dq_en), .cyc_type(cyc_type)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_mask(input logic [1:0] l);
        return {{8{l[1]}}, {8{l[0]}}};
    endfunction

    function automatic int idx(input logic [K-1:0] r, input logic [K-1:0] c);
        return int'({r, c});
    endfunction

    task automatic ref_write(input int a, input logic [1:0] l, input logic [15:0] d);
        ref_mem[a] = (ref_mem[a] & ~lane_mask(l)) | (d & lane_mask(l));
    endtask

    task automatic idle();
        ras_n = 1; ucas_n = 1; lcas_n = 1; we_n = 1; oe_n = 1;
    endtask

    task automatic rd_cycle(input logic [K-1:0] r, input logic [K-1:0] c,
                            input logic [1:0] l, input bit oe_on, input string tg);
        addr = r; ras_n = 0; step();
        check("R9 row-only class before CAS", 32'(cyc_type), 6);
        addr = c; oe_n = !oe_on; ucas_n = !l[1]; lcas_n = !l[0]; step();
        check("R4 read class", 32'(cyc_type), oe_on ? 1 : 7);
        check("R4 lane enables", 32'(dq_en), oe_on ? 32'(l) : 0);
        if (oe_on) check(tg, 32'(dq_out & lane_mask(l)), 32'(ref_mem[idx(r, c)] & lane_mask(l)));
        ucas_n = 1; lcas_n = 1; step();
        check("R5 data held after CAS rise", 32'(dq_en), oe_on ? 32'(l) : 0);
        ras_n = 1; step();
        check("R5 release on full precharge", 32'(dq_en), 0);
        oe_n = 1; step();
    endtask

    task automatic ewr_cycle(input logic [K-1:0] r, input logic [K-1:0] c,
                             input logic [1:0] l, input logic [15:0] d);
        addr = r; ras_n = 0; step();
        addr = c; we_n = 0; din = d; ucas_n = !l[1]; lcas_n = !l[0]; step();
        check("R3 early write class", 32'(cyc_type), 2);
        check("R3 early write outputs off", 32'(dq_en), 0);
        ref_write(idx(r, c), l, d);
        idle(); step();
        check("R3 still off after cycle", 32'(dq_en), 0);
    endtask

    task automatic dwr_cycle(input logic [K-1:0] r, input logic [K-1:0] c,
                             input logic [1:0] l, input logic [15:0] d, input bit rmw);
        addr = r; ras_n = 0; step();
        addr = c; oe_n = !rmw; ucas_n = !l[1]; lcas_n = !l[0]; step();
        if (rmw) check("R8 read shown before write", 32'(dq_out & lane_mask(l)),
                       32'(ref_mem[idx(r, c)] & lane_mask(l)));
        oe_n = 1; step();
        din = d; we_n = 0; step();
        check("R8 late write class", 32'(cyc_type), rmw ? 4 : 3);
        check("R8 outputs off during write", 32'(dq_en), 0);
        ref_write(idx(r, c), l, d);
        idle(); step();
    endtask

    task automatic cbr_cycle(input logic [1:0] l, input logic [15:0] junk);
        din = junk; we_n = 0; ucas_n = !l[1]; lcas_n = !l[0]; step();
        ras_n = 0; step();
        check("R1 refresh class", 32'(cyc_type), 5);
        check("R1 refresh outputs off", 32'(dq_en), 0);
        ras_n = 1; step();
        idle(); step();
    endtask

    task automatic ror_cycle(input logic [K-1:0] r);
        addr = r; ras_n = 0; step();
        check("R9 row-only class", 32'(cyc_type), 6);
        check("R9 outputs open", 32'(dq_en), 0);
        ras_n = 1; step();
        check("R11 class held after cycle", 32'(cyc_type), 6);
    endtask

    task automatic open_read(input logic [K-1:0] r, input logic [K-1:0] c);
        addr = r; ras_n = 0; step();
        addr = c; oe_n = 0; ucas_n = 0; lcas_n = 0; step();
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) ref_mem[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) step();
        rst_n = 1; step();
        check("R11 reset class", 32'(cyc_type), 0);
        check("R11 reset outputs off", 32'(dq_en), 0);

        ewr_cycle(3'd2, 3'd5, 2'b11, 16'h1234);
        rd_cycle(3'd2, 3'd5, 2'b11, 1, "R2 full word stored");
        ewr_cycle(3'd2, 3'd5, 2'b01, 16'hFFEE);
        rd_cycle(3'd2, 3'd5, 2'b11, 1, "R2 only lower lane changed");
        ewr_cycle(3'd2, 3'd5, 2'b10, 16'hABFF);
        rd_cycle(3'd2, 3'd5, 2'b11, 1, "R2 only upper lane changed");
        cbr_cycle(2'b11, 16'hDEAD);
        rd_cycle(3'd2, 3'd5, 2'b11, 1, "R1 array untouched by refresh");
        ror_cycle(3'd2);
        rd_cycle(3'd2, 3'd5, 2'b11, 1, "R9 array untouched by row refresh");
        dwr_cycle(3'd3, 3'd4, 2'b11, 16'hBEEF, 0);
        rd_cycle(3'd3, 3'd4, 2'b11, 1, "R8 delayed write stored");
        dwr_cycle(3'd3, 3'd4, 2'b10, 16'h0F0F, 1);
        rd_cycle(3'd3, 3'd4, 2'b11, 1, "R8 rmw stored upper lane");
        rd_cycle(3'd3, 3'd4, 2'b01, 0, "R4 output-disabled read");

        // R10 page mode
        ewr_cycle(3'd2, 3'd3, 2'b11, 16'h5A5A);
        open_read(3'd2, 3'd5);
        check("R10 first page access", 32'(dq_out), 32'(ref_mem[idx(3'd2, 3'd5)]));
        ucas_n = 1; lcas_n = 1; step();
        addr = 3'd3; ucas_n = 0; lcas_n = 0; step();
        check("R10 second page access", 32'(dq_out), 32'(ref_mem[idx(3'd2, 3'd3)]));
        check("R10 page access class", 32'(cyc_type), 1);
        idle(); step();

        // R6 OE rise while CAS high
        open_read(3'd2, 3'd5);
        ucas_n = 1; lcas_n = 1; step();
        oe_n = 1; step();
        check("R6 OE rise turns off", 32'(dq_en), 0);
        oe_n = 0; step();
        check("R6 stays off until next access", 32'(dq_en), 0);
        ucas_n = 0; lcas_n = 0; step();
        check("R6 next access drives again", 32'(dq_en), 3);
        oe_n = 1; step();
        check("R6 OE rise with CAS low turns off", 32'(dq_en), 0);
        oe_n = 0; step();
        check("R6 OE fall with CAS low restores", 32'(dq_en), 3);
        idle(); step();

        // R7 WE fall while CAS high
        open_read(3'd3, 3'd4);
        ucas_n = 1; lcas_n = 1; step();
        check("R7 driven before WE fall", 32'(dq_en), 3);
        we_n = 0; step();
        check("R7 WE fall turns off", 32'(dq_en), 0);
        we_n = 1; step();
        check("R7 stays off until next access", 32'(dq_en), 0);
        idle(); step();

        // R12 late lane joins
        addr = 3'd3; ras_n = 0; step();
        addr = 3'd4; oe_n = 0; ucas_n = 0; step();
        check("R12 first lane only", 32'(dq_en), 2);
        lcas_n = 0; step();
        check("R12 second lane joins", 32'(dq_en), 3);
        check("R12 full word data", 32'(dq_out), 32'(ref_mem[idx(3'd3, 3'd4)]));
        idle(); step();

        for (int it = 0; it < 250; it++) begin
            logic [K-1:0] r, c;
            logic [1:0] l;
            logic [15:0] d;
            r = K'($urandom_range(0, (1 << K) - 1));
            c = K'($urandom_range(0, (1 << K) - 1));
            l = 2'($urandom_range(1, 3));
            d = 16'($urandom());
            case ($urandom_range(0, 5))
                0: ewr_cycle(r, c, l, d);
                1: dwr_cycle(r, c, l, d, 0);
                2: dwr_cycle(r, c, l, d, 1);
                3: cbr_cycle(l, d);
                4: ror_cycle(r);
                default: rd_cycle(r, c, l, 1, "R4 random read data");
            endcase
        end
        for (int a = 0; a < WORDS; a++)
            rd_cycle(K'(a >> K), K'(a), 2'b11, 1, "R2 final array sweep");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule